// File: doc/BRIEF.md
# Up/Down Binary Counter with Direction-Aware Terminal Count

This block is a parameterized binary counter for datapath use. A state register holds the count. Its next value comes from one of two arithmetic paths: an incrementer made from a chain of half adders, or a decrementer made from full adders with a constant all-ones addend. A direction input picks the path. The count advances only while the enable input is high. A synchronous clear and a parallel load take precedence over counting, and the count wraps silently at both ends of its range.

The same direction input also picks which end-of-range detector drives the terminal-count output. When counting up, the detector flags all ones. When counting down, it flags all zeros. A controller can therefore read `tc_o` as "the next enabled step wraps", whichever way the counter is running.

Top module: `updown_tc_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes zero on that edge.
- R2: `clr_i` high sets the count to zero on the next edge. It overrides `load_i` and `step_en_i`.
- R3: With `clr_i` low and `load_i` high, the count takes `load_val_i` on the next edge, whatever the value of `step_en_i`.
- R4: With `clr_i`, `load_i` and `step_en_i` all low, the count holds its value across the edge.
- R5: With only `step_en_i` high and `up_i` = 1, the count becomes count + 1 modulo 2^WIDTH.
- R6: With only `step_en_i` high and `up_i` = 0, the count becomes count − 1 modulo 2^WIDTH.
- R7: An up step from all ones gives zero. A down step from zero gives all ones.
- R8: When `up_i` = 1, `tc_o` is high exactly when every bit of the count is 1.
- R9: When `up_i` = 0, `tc_o` is high exactly when every bit of the count is 0.
- R10: `tc_o` is combinational from the count and `up_i`. It follows a change of `up_i` in the same cycle and does not depend on `step_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear to zero |
| load_i | input | 1 | Parallel load strobe |
| load_val_i | input | WIDTH | Value written by a load |
| step_en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 up, 0 down |
| count_o | output | WIDTH | Registered count |
| tc_o | output | 1 | Terminal count for the current direction |

## Verification
Clear, load, hold and both count directions take effect on the first rising edge after the controls are applied. The bench drives the controls on a falling edge and compares `count_o` with its own model at the next falling edge. `tc_o` has no register, so it is checked one time unit after each change of the inputs, against the model count and the direction just driven. That check is made with the enable both high and low. Directed runs across both wrap points and a toggle of `up_i` at the range ends are mixed with seeded random traffic.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;
  localparam logic DIR_UP   = 1'b1;
  localparam logic DIR_DOWN = 1'b0;

  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_STEP  = 2'd1,
    SEL_LOAD  = 2'd2,
    SEL_CLEAR = 2'd3
  } next_sel_e;
endpackage

// File: rtl/cnt_incr.sv
module cnt_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] sum_o
);
  // half-adder chain, constant 1 injected at the LSB
  logic [WIDTH-1:0] carry;
  assign carry[0] = 1'b1;
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_ha
      assign sum_o[i] = a_i[i] ^ carry[i];
      if (i < WIDTH-1) begin : g_c
        assign carry[i+1] = a_i[i] & carry[i];
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_decr.sv
module cnt_decr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] diff_o
);
  // full-adder chain adding all ones (two's complement of 1), carry-in 0
  logic [WIDTH-1:0] carry;
  assign carry[0] = 1'b0;
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_fa
      assign diff_o[i] = a_i[i] ^ 1'b1 ^ carry[i];
      if (i < WIDTH-1) begin : g_c
        assign carry[i+1] = a_i[i] | carry[i];
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic             up_i,
  output logic             tc_o
);
  import updown_cnt_pkg::*;
  logic all_ones;
  logic all_zeros;
  assign all_ones  = &value_i;
  assign all_zeros = ~|value_i;
  assign tc_o = (up_i == DIR_UP) ? all_ones : all_zeros;
endmodule

// File: rtl/updown_tc_counter.sv
module updown_tc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_en_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  import updown_cnt_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO     = '0;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;
  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] next_val;
  next_sel_e        sel;

  cnt_incr #(.WIDTH(WIDTH)) u_inc (.a_i(cnt_q), .sum_o(inc_val));
  cnt_decr #(.WIDTH(WIDTH)) u_dec (.a_i(cnt_q), .diff_o(dec_val));
  cnt_term_detect #(.WIDTH(WIDTH)) u_tc (.value_i(cnt_q), .up_i(up_i), .tc_o(tc_o));

  // priority: clear, then load, then count enable
  always_comb begin
    if (clr_i)          sel = SEL_CLEAR;
    else if (load_i)    sel = SEL_LOAD;
    else if (step_en_i) sel = SEL_STEP;
    else                sel = SEL_HOLD;
  end

  assign step_val = (up_i == DIR_UP) ? inc_val : dec_val;

  always_comb begin
    unique case (sel)
      SEL_CLEAR: next_val = ZERO;
      SEL_LOAD:  next_val = load_val_i;
      SEL_STEP:  next_val = step_val;
      default:   next_val = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= next_val;
  end

  assign count_o = cnt_q;

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> count_o == ZERO);
  // R2
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> count_o == ZERO);
  // R3
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && load_i) |=> count_o == $past(load_val_i));
  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && !step_en_i) |=> $stable(count_o));
  // R5
  a_r5_up: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && step_en_i && up_i) |=> count_o == $past(count_o) + 1'b1);
  // R6
  a_r6_down: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && step_en_i && !up_i) |=> count_o == $past(count_o) - 1'b1);
  // R7, R8: an up step taken while tc is flagged lands on zero
  a_r7_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && step_en_i && up_i && tc_o) |=> count_o == ZERO);
  // R7, R9: a down step taken while tc is flagged lands on all ones
  a_r7_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && step_en_i && !up_i && tc_o) |=> count_o == ALL_ONES);
  // R10: a held count with a held direction keeps tc steady
  a_r10_tc_steady: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && !step_en_i) ##1 $stable(up_i) |-> $stable(tc_o));
endmodule

// File: tb/updown_tc_counter_test.sv
module updown_tc_counter_test;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0, ld = 1'b0, en = 1'b0, up = 1'b1;
  logic [W-1:0] ldv = '0;
  logic [W-1:0] cnt;
  logic tc;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updown_tc_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .clr_i(clr), .load_i(ld), .load_val_i(ldv),
    .step_en_i(en), .up_i(up), .count_o(cnt), .tc_o(tc)
  );

  function automatic logic [W-1:0] next_of(logic [W-1:0] cur, logic c, logic l,
                                           logic [W-1:0] v, logic e, logic d);
    if (c) return '0;
    if (l) return v;
    if (!e) return cur;
    return d ? cur + 1'b1 : cur - 1'b1;
  endfunction

  function automatic logic tc_of(logic [W-1:0] cur, logic d);
    return d ? (cur == ONES) : (cur == '0);
  endfunction

  task automatic check_cnt(string tag);
    checks++;
    if (cnt !== model) begin
      failures++;
      $display("FAIL %s count actual=%0h expected=%0h", tag, cnt, model);
    end
  endtask

  task automatic check_tc(string tag);
    logic e;
    e = tc_of(model, up);
    checks++;
    if (tc !== e) begin
      failures++;
      $display("FAIL %s tc actual=%0b expected=%0b (count=%0h up=%0b)", tag, tc, e, model, up);
    end
  endtask

  // called at a falling edge: apply inputs, check tc, then check count one cycle later
  task automatic step(logic c, logic l, logic [W-1:0] v, logic e, logic d, string tag);
    clr = c; ld = l; ldv = v; en = e; up = d;
    #1;
    check_tc(up ? "R8/R10" : "R9/R10");
    model = next_of(model, c, l, v, e, d);
    @(negedge clk);
    check_cnt(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_cnt("R1 reset");
    // R5 up steps and R7 wrap up
    step(0, 1, ONES - 4'd1, 0, 1, "R3 load without enable");
    step(0, 0, '0, 1, 1, "R5 up to all ones");
    step(0, 0, '0, 0, 1, "R4 hold at all ones");   // tc R8 high, en low (R10)
    step(0, 0, '0, 1, 1, "R7 wrap up to zero");
    // R6 down and R7 wrap down, tc direction toggle (R10)
    step(0, 0, '0, 0, 1, "R4 hold at zero up dir");  // tc low: up, count zero
    step(0, 0, '0, 0, 0, "R4 hold at zero down dir");// tc high: R9 same cycle
    step(0, 0, '0, 1, 0, "R7 wrap down to all ones");
    step(0, 0, '0, 1, 0, "R6 down step");
    // R2 priority over load and enable
    step(1, 1, 4'h9, 1, 1, "R2 clear beats load");
    step(0, 1, 4'h6, 1, 0, "R3 load beats enable");
    step(0, 0, '0, 0, 0, "R4 hold");
    step(1, 0, '0, 0, 0, "R2 clear without enable");
    // R1 reset mid-run
    step(0, 1, 4'hA, 0, 1, "R3 load A");
    rst = 1'b1; model = '0;
    @(negedge clk);
    rst = 1'b0;
    check_cnt("R1 reset mid-run");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic c, l, e, d;
      logic [W-1:0] v;
      c = ($urandom % 16) == 0;
      l = ($urandom % 8) == 0;
      e = ($urandom % 4) != 0;
      d = $urandom % 2;
      v = W'($urandom);
      step(c, l, v, e, d, d ? "R5/R7 random" : "R6/R7 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule